// File: doc/BRIEF.md
# Blanking Packet Stream Generator

This block produces one long blanking (filler) packet as a stream of bytes. It is used for the horizontal sync-active, back porch, front porch and full horizontal blanking intervals. A caller pulses `start_i` with the following settings:

- the interval kind,
- the interval length in pixels,
- the bytes per pixel,
- a virtual channel,
- a pad byte.

The block works out the payload length from these settings. It then sends a 4-byte header protected by ECC, the pad bytes as the payload, and a 2-byte payload checksum.

Each byte leaves on a valid/ready handshake. A one-cycle done pulse marks the end of the packet. While a packet is in flight, new start requests are ignored. Distribution of bytes onto lanes and the video timing master sit outside this block.

Top module: `blank_pkt_gen`

## Requirements
- R1: After reset, `valid_o`, `busy_o` and `done_o` are all low.
- R2: Header byte 0 is `{vc_i, 6'h19}`, with the channel in bits 7:6 and data type 0x19 in bits 5:0. Bytes 1 and 2 carry the 16-bit word count, low byte first.
- R3: Header byte 3 is the 6-bit Hamming parity used for DSI packet headers, computed over header bits 23:0, with bits 7:6 zero.
- R4: The word count is `pixels_i*bpp_i - ovh`. The overhead `ovh` depends on `kind_i`: 0 (sync active) gives 10, 1 (back porch) gives 6, 2 (front porch) gives 16, 3 (full blanking) gives 10.
- R5: When `pixels_i*bpp_i - ovh` would be below `ovh`, the word count is `ovh`.
- R6: The payload has word-count bytes, and every one equals the `pad_i` value captured at start.
- R7: The two bytes after the payload are a CRC over the payload only. It uses the reflected polynomial 0x8408, is seeded with 0xFFFF, takes each byte LSB first, and is sent low byte first.
- R8: While `valid_o` is high and `ready_i` is low, `byte_o` and `valid_o` hold their values in the next cycle.
- R9: `done_o` pulses high for exactly one cycle, in the cycle after the last CRC byte is accepted. `busy_o` is low in that cycle.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The packet in flight is unchanged.
- R11: `valid_o` rises in the cycle after an accepted start and stays high until all word-count+6 bytes are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| kind_i | input | 2 | Interval kind, selects the overhead |
| pixels_i | input | PIX_W | Interval length in pixels |
| bpp_i | input | BPP_W | Bytes per pixel |
| vc_i | input | 2 | Virtual channel |
| pad_i | input | 8 | Payload pad byte |
| ready_i | input | 1 | Sink accepts the byte |
| valid_o | output | 1 | Byte is valid |
| byte_o | output | 8 | Packet byte |
| busy_o | output | 1 | Packet in flight |
| done_o | output | 1 | One-cycle end-of-packet pulse |

## Verification
The bench sweeps all four interval kinds against bytes per pixel from 1 to 4 and a spread of pixel counts. The sweep covers the region where the overhead clamp applies, the region where it does not, and the exact boundary between them, so the two length rules are told apart. Several pad values separate pad-driven CRC results from a fixed CRC. Channel values vary, so a misplaced channel field shows up in the header and ECC.

Three ready patterns are used: always ready, every third cycle stalled, and alternating. They expose handshake bugs that move on a stalled byte or skip a byte. Some packets receive a second start with different settings partway through, to prove the request is ignored.

// File: rtl/blank_pkt_pkg.sv
package blank_pkt_pkg;
  localparam logic [5:0] DT_BLANK = 6'h19;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY, ST_CRC} st_e;

  function automatic logic [4:0] kind_ovh(input logic [1:0] k);
    case (k)
      2'd0:    return 5'd10;
      2'd1:    return 5'd6;
      2'd2:    return 5'd16;
      default: return 5'd10;
    endcase
  endfunction

  function automatic logic [23:0] ecc_mask(input int p);
    case (p)
      0:       return 24'hF12CB7;
      1:       return 24'hF2555B;
      2:       return 24'h749A6D;
      3:       return 24'hB8E38E;
      4:       return 24'hDF03F0;
      default: return 24'hEFFC00;
    endcase
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/blank_len_calc.sv
module blank_len_calc #(
  parameter int PIX_W = 12,
  parameter int BPP_W = 3,
  parameter int WC_W  = 16
) (
  input  logic [1:0]       kind_i,
  input  logic [PIX_W-1:0] pixels_i,
  input  logic [BPP_W-1:0] bpp_i,
  output logic [WC_W-1:0]  wc_o
);
  import blank_pkt_pkg::*;
  localparam int RAW_W = PIX_W + BPP_W + 1;

  logic [RAW_W-1:0] raw, ovh;

  always_comb begin
    raw = RAW_W'(pixels_i) * RAW_W'(bpp_i);
    ovh = RAW_W'(kind_ovh(kind_i));
    // clamp: never below the overhead itself
    if (raw >= (ovh << 1)) wc_o = WC_W'(raw - ovh);
    else                   wc_o = WC_W'(ovh);
  end
endmodule

// File: rtl/blank_hdr_ecc.sv
module blank_hdr_ecc (
  input  logic [23:0] hdr_i,
  output logic [7:0]  ecc_o
);
  import blank_pkt_pkg::*;

  for (genvar p = 0; p < 6; p++) begin : g_par
    assign ecc_o[p] = ^(hdr_i & ecc_mask(p));
  end
  assign ecc_o[7:6] = 2'b00;
endmodule

// File: rtl/blank_crc.sv
module blank_crc (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  import blank_pkt_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= 16'hFFFF;
    else if (init_i) crc_o <= 16'hFFFF;
    else if (en_i)   crc_o <= crc_step(crc_o, data_i);
  end
endmodule

// File: rtl/blank_pkt_gen.sv
module blank_pkt_gen #(
  parameter int PIX_W = 12,
  parameter int BPP_W = 3,
  parameter int WC_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       kind_i,
  input  logic [PIX_W-1:0] pixels_i,
  input  logic [BPP_W-1:0] bpp_i,
  input  logic [1:0]       vc_i,
  input  logic [7:0]       pad_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [7:0]       byte_o,
  output logic             busy_o,
  output logic             done_o
);
  import blank_pkt_pkg::*;
  localparam int HDR_W = WC_W + 8;

  st_e              state_q;
  logic [WC_W-1:0]  wc_calc, cnt_q;
  logic [HDR_W-1:0] hdr_q;
  logic [WC_W-1:0]  wc_q;
  logic [7:0]       pad_q, ecc_w;
  logic [15:0]      crc_w;
  logic             fire, take;

  blank_len_calc #(.PIX_W(PIX_W), .BPP_W(BPP_W), .WC_W(WC_W)) u_len (
    .kind_i(kind_i), .pixels_i(pixels_i), .bpp_i(bpp_i), .wc_o(wc_calc)
  );

  blank_hdr_ecc u_ecc (.hdr_i(hdr_q[23:0]), .ecc_o(ecc_w));

  blank_crc u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(take),
    .en_i(fire && state_q == ST_PAY), .data_i(pad_q), .crc_o(crc_w)
  );

  assign wc_q    = hdr_q[HDR_W-1:8];
  assign valid_o = (state_q != ST_IDLE);
  assign busy_o  = valid_o;
  assign fire    = valid_o && ready_i;
  assign take    = start_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      pad_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (take) begin
          hdr_q   <= {wc_calc, vc_i, DT_BLANK};
          pad_q   <= pad_i;
          cnt_q   <= '0;
          state_q <= ST_HDR;
        end
        ST_HDR: if (fire) begin
          if (cnt_q == WC_W'(3)) begin
            cnt_q   <= '0;
            state_q <= (wc_q == '0) ? ST_CRC : ST_PAY;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_PAY: if (fire) begin
          if (cnt_q == wc_q - 1'b1) begin
            cnt_q   <= '0;
            state_q <= ST_CRC;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_CRC: if (fire) begin
          if (cnt_q[0]) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    byte_o = 8'h00;
    unique case (state_q)
      ST_HDR: begin
        case (cnt_q[1:0])
          2'd0:    byte_o = hdr_q[7:0];
          2'd1:    byte_o = hdr_q[15:8];
          2'd2:    byte_o = hdr_q[23:16];
          default: byte_o = ecc_w;
        endcase
      end
      ST_PAY:  byte_o = pad_q;
      ST_CRC:  byte_o = cnt_q[0] ? crc_w[15:8] : crc_w[7:0];
      default: byte_o = 8'h00;
    endcase
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(byte_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(hdr_q) && $stable(pad_q));

  p_wc_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> wc_q >= WC_W'(6));

  p_valid_run_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !(fire && state_q == ST_CRC && cnt_q[0]) |=> valid_o);
endmodule

// File: tb/tb_blank_pkt_gen.sv
module tb_blank_pkt_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 12;
  localparam int BPP_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ready = 1'b0;
  logic [1:0] kind = '0, vc = '0;
  logic [PIX_W-1:0] pixels = '0;
  logic [BPP_W-1:0] bpp = '0;
  logic [7:0] pad = '0;
  logic valid, busy, done;
  logic [7:0] byte_w;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  logic [7:0] exp_b [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  blank_pkt_gen #(.PIX_W(PIX_W), .BPP_W(BPP_W), .WC_W(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .kind_i(kind),
    .pixels_i(pixels), .bpp_i(bpp), .vc_i(vc), .pad_i(pad),
    .ready_i(ready), .valid_o(valid), .byte_o(byte_w),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] ref_ecc(input logic [23:0] d);
    logic [7:0] e;
    e = '0;
    e[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
    e[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
    e[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
    e[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
    e[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
    e[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
    return e;
  endfunction

  function automatic logic [15:0] ref_crc(input logic [7:0] p, input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, p};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  function automatic bit rdy_pat(input int mode, input int t);
    case (mode)
      0:       return 1'b1;
      1:       return (t % 3) != 2;
      default: return t[0];
    endcase
  endfunction

  task automatic run_pkt(input int k, input int px, input int bp, input int v,
                         input int pd, input int mode, input bit inject);
    int ovh, raw, wc, n, idx, t;
    bit clamped, was_stall;
    logic [7:0] held;
    logic [23:0] h;
    logic [15:0] c;
    string tag;
    ovh = (k == 1) ? 6 : (k == 2) ? 16 : 10;
    raw = px * bp;
    clamped = (raw - ovh) < ovh;
    wc = clamped ? ovh : raw - ovh;
    h = {wc[15:0], v[1:0], 6'h19};
    c = ref_crc(pd[7:0], wc);
    n = wc + 6;
    exp_b[0] = h[7:0]; exp_b[1] = h[15:8]; exp_b[2] = h[23:16];
    exp_b[3] = ref_ecc(h);
    for (int i = 0; i < wc; i++) exp_b[4+i] = pd[7:0];
    exp_b[4+wc] = c[7:0]; exp_b[5+wc] = c[15:8];

    @(negedge clk);
    kind = k[1:0]; pixels = px[PIX_W-1:0]; bpp = bp[BPP_W-1:0];
    vc = v[1:0]; pad = pd[7:0]; start = 1'b1; ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    idx = 0; t = 0; was_stall = 0; held = '0;
    while (idx < n) begin
      ready = rdy_pat(mode, t);
      start = inject && (idx == 3 || idx == n - 2);
      if (start) begin
        vc = ~v[1:0]; pad = ~pd[7:0]; kind = ~k[1:0]; pixels = 12'd200;
      end
      #1;
      if (was_stall) chk(valid && byte_w == held, "R8", byte_w, held);
      if (!valid) begin
        chk(0, "R11", 0, 1);
        idx = n;
      end else if (ready) begin
        if (idx == 0)          tag = "R2";
        else if (idx < 3)      tag = clamped ? "R5" : "R4";
        else if (idx == 3)     tag = "R3";
        else if (idx < 4 + wc) tag = inject ? "R10" : "R6";
        else                   tag = "R7";
        chk(byte_w == exp_b[idx], tag, byte_w, exp_b[idx]);
        idx++;
        was_stall = 0;
      end else begin
        was_stall = 1;
        held = byte_w;
      end
      t++;
      @(negedge clk);
    end
    start = 1'b0;
    ready = 1'b0;
    #1;
    chk(done == 1'b1 && busy == 1'b0, "R9", {busy, done}, 1);
    @(negedge clk);
    #1;
    chk(done == 1'b0 && valid == 1'b0, "R9", {valid, done}, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int pix_set [8];
    int sel;
    pix_set = '{0, 1, 3, 5, 8, 12, 20, 40};
    #(CLK_PERIOD * 2);
    #1;
    chk(valid == 0 && busy == 0 && done == 0, "R1", {valid, busy, done}, 0);
    rst_n = 1'b1;
    sel = 0;
    for (int k = 0; k < 4; k++)
      for (int bp = 1; bp <= 4; bp++)
        for (int p = 0; p < 8; p++) begin
          run_pkt(k, pix_set[p], bp, sel % 4, (sel * 37 + 5) % 256, sel % 3, (sel % 5) == 2);
          sel++;
        end
    // exact clamp boundaries: raw == 2*ovh and raw == 2*ovh-1
    run_pkt(2, 32, 1, 1, 8'hA5, 1, 0);
    run_pkt(2, 31, 1, 2, 8'h5A, 2, 0);
    run_pkt(1, 3, 4, 3, 8'hFF, 0, 0);
    run_pkt(0, 19, 1, 0, 8'h00, 1, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule